// File: doc/BRIEF.md
# RC Link Failsafe and Arm Supervisor

This block sits behind a radio-control frame receiver and decides whether the vehicle may be armed. Each time a complete channel frame arrives, the receiver pulses an update strobe together with two decoded channel values: the arm switch channel and the steering channel. The block also reads a free-running 32-bit millisecond time value. From these inputs it tracks whether the radio link is alive, requests a disarm when the link goes stale while the vehicle is armed, and turns the arm switch into arm and cancel requests. It also scales the steering channel to a signed command.

Failsafe starts only after the first frame has arrived. A system that runs with no radio attached is therefore never disarmed because frames are missing. Arming does not follow the switch level. It follows the edges of a qualified state, defined as the link being alive and the switch being on. A rising edge can start an arm sequence, but only when the sensors are calibrated, the system is disarmed and the tilt is within limit. A falling edge always cancels, and it also disarms when the system is armed. The arm-hold timing and the balance loop are outside this block; they consume the request pulses.

Top module: `rc_arm_supervisor`

## Requirements
- R1: After reset, armStart, cancelReq, disarmReq and linkAlive are 0 and steerCmd is 0.
- R2: The arm switch counts as on only when armChan is strictly greater than 1750, so the value 1750 counts as off. armChan is sampled when chanValid is high.
- R3: linkAlive is 1 when at least one frame has been received and nowMs minus the nowMs of the last frame is at most 300. It is 0 before the first frame.
- R4: While sysArmed is 1, a frame has been seen and more than 300 ms have passed since the last frame, cancelReq and disarmReq are both 1 on every cycle. When sysArmed is 0, the stale link alone raises neither output.
- R5: Before the first frame after reset, no amount of elapsed time raises disarmReq, cancelReq or linkAlive.
- R6: On a 0-to-1 change of (linkAlive condition AND switch on), armStart is a one-cycle pulse, given only when sensorCal, sysDisarmed and tiltOk are all 1. A switch that stays on gives no further pulse.
- R7: On a 1-to-0 change of the qualified state, whether caused by the switch or by link loss, cancelReq pulses for one cycle. disarmReq pulses with it when sysArmed is 1.
- R8: steerCmd = -400 + floor((steerChan - 172) * 800 / 1639). A steerChan of 172 or less gives -400, and a steerChan of 1811 or more gives +400.
- R9: The stored previous qualified state resets to off. As a result, the first frame after reset with the switch on counts as a rising edge.
- R10: Elapsed time uses unsigned 32-bit subtraction, so liveness stays correct when nowMs wraps past zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| armChan | input | 11 | Raw arm switch channel value |
| steerChan | input | 11 | Raw steering channel value |
| chanValid | input | 1 | One-cycle strobe: a valid channel frame has arrived |
| nowMs | input | 32 | Free-running millisecond time |
| sensorCal | input | 1 | Sensors are calibrated |
| sysDisarmed | input | 1 | System is currently disarmed |
| sysArmed | input | 1 | System is currently armed |
| tiltOk | input | 1 | Tilt is within the arming limit |
| armStart | output | 1 | Request to start the arm-hold sequence |
| cancelReq | output | 1 | Request to cancel a pending arm |
| disarmReq | output | 1 | Request to disarm |
| linkAlive | output | 1 | The radio link is live |
| steerCmd | output | 16 | Signed steering command, -400 to +400 |

## Verification
Frame-driven results take two clock edges. The strobe edge captures the frame, and the following edge registers armStart, cancelReq, disarmReq, linkAlive and steerCmd. Time-driven results take one edge: a change of nowMs or sysArmed shows on the outputs after the next edge, because the last frame time is already stored. Each stimulus task records its expected outputs with a due cycle at that offset, and the monitor compares them at the falling edge of that cycle. Pulse widths are checked by a second expectation one cycle later.

// File: rtl/rc_sup_pkg.sv
package rc_sup_pkg;

  // Strobes issued by control to the datapath.
  typedef struct packed {
    logic capture;    // latch channel values and the frame time
    logic steerLoad;  // register the scaled steering value
  } ctrlStrobe_t;

  // Link status returned by the datapath.
  typedef struct packed {
    logic seen;   // at least one frame since reset
    logic alive;  // seen and within the timeout window
    logic stale;  // elapsed time exceeds the timeout
    logic armOn;  // latched switch is above threshold
  } linkStat_t;

endpackage

// File: rtl/rc_steer_map.sv
module rc_steer_map #(
  parameter int CH_W    = 11,
  parameter int CMD_W   = 16,
  parameter int RAW_MIN = 172,
  parameter int RAW_MAX = 1811,
  parameter int OUT_MAX = 400
) (
  input  logic [CH_W-1:0]         rawVal,
  output logic signed [CMD_W-1:0] cmdVal
);
  localparam int SPAN = RAW_MAX - RAW_MIN;
  localparam int FULL = 2 * OUT_MAX;
  localparam logic [CH_W-1:0] RAW_LO = CH_W'(RAW_MIN);
  localparam logic [CH_W-1:0] RAW_HI = CH_W'(RAW_MAX);
  localparam logic signed [CMD_W-1:0] POS_LIM = CMD_W'(OUT_MAX);
  localparam logic signed [CMD_W-1:0] NEG_LIM = -POS_LIM;

  logic [31:0] offset;
  logic [31:0] scaled;
  logic [31:0] quotient;

  always_comb begin
    offset   = 32'(rawVal) - 32'(RAW_MIN);
    scaled   = offset * 32'(FULL);
    quotient = scaled / 32'(SPAN);
    if (rawVal <= RAW_LO)
      cmdVal = NEG_LIM;
    else if (rawVal >= RAW_HI)
      cmdVal = POS_LIM;
    else
      cmdVal = $signed(CMD_W'(quotient)) - POS_LIM;
  end
endmodule

// File: rtl/rc_sup_datapath.sv
module rc_sup_datapath
  import rc_sup_pkg::*;
#(
  parameter int CH_W       = 11,
  parameter int TIME_W     = 32,
  parameter int CMD_W      = 16,
  parameter int ARM_THRESH = 1750,
  parameter int TIMEOUT_MS = 300,
  parameter int RAW_MIN    = 172,
  parameter int RAW_MAX    = 1811,
  parameter int OUT_MAX    = 400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CH_W-1:0]         armChan,
  input  logic [CH_W-1:0]         steerChan,
  input  logic [TIME_W-1:0]       nowMs,
  input  ctrlStrobe_t             strobe,
  output linkStat_t               stat,
  output logic signed [CMD_W-1:0] steerCmd
);
  localparam logic [CH_W-1:0]   ARM_LIM  = CH_W'(ARM_THRESH);
  localparam logic [TIME_W-1:0] TOUT_LIM = TIME_W'(TIMEOUT_MS);
  localparam logic [CH_W-1:0]   RAW_MID  = CH_W'((RAW_MIN + RAW_MAX) / 2);

  logic                    seenQ;
  logic                    armOnQ;
  logic [TIME_W-1:0]       lastRxQ;
  logic [CH_W-1:0]         steerRawQ;
  logic signed [CMD_W-1:0] steerCmdQ;
  logic signed [CMD_W-1:0] steerMapped;
  logic [TIME_W-1:0]       elapsed;
  logic                    staleNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenQ     <= 1'b0;
      armOnQ    <= 1'b0;
      lastRxQ   <= '0;
      steerRawQ <= RAW_MID;
    end else if (strobe.capture) begin
      seenQ     <= 1'b1;
      armOnQ    <= (armChan > ARM_LIM);
      lastRxQ   <= nowMs;
      steerRawQ <= steerChan;
    end
  end

  // Unsigned difference stays correct across a wrap of nowMs.
  always_comb begin
    elapsed  = nowMs - lastRxQ;
    staleNow = (elapsed > TOUT_LIM);
  end

  rc_steer_map #(
    .CH_W   (CH_W),
    .CMD_W  (CMD_W),
    .RAW_MIN(RAW_MIN),
    .RAW_MAX(RAW_MAX),
    .OUT_MAX(OUT_MAX)
  ) u_map (
    .rawVal(steerRawQ),
    .cmdVal(steerMapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      steerCmdQ <= '0;
    else if (strobe.steerLoad)
      steerCmdQ <= steerMapped;
  end

  always_comb begin
    stat.seen  = seenQ;
    stat.stale = staleNow;
    stat.alive = seenQ & ~staleNow;
    stat.armOn = armOnQ;
    steerCmd   = steerCmdQ;
  end
endmodule

// File: rtl/rc_sup_control.sv
module rc_sup_control
  import rc_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chanValid,
  input  linkStat_t   stat,
  input  logic        sensorCal,
  input  logic        sysDisarmed,
  input  logic        sysArmed,
  input  logic        tiltOk,
  output ctrlStrobe_t strobe,
  output logic        armStart,
  output logic        cancelReq,
  output logic        disarmReq,
  output logic        linkAlive
);
  logic qualNow;
  logic qualPrevQ;
  logic qualRise;
  logic qualFall;
  logic failsafe;
  logic armGate;
  logic steerLoadQ;
  logic armStartQ;
  logic cancelQ;
  logic disarmQ;
  logic aliveQ;

  always_comb begin
    qualNow  = stat.alive & stat.armOn;
    qualRise = qualNow & ~qualPrevQ;
    qualFall = ~qualNow & qualPrevQ;
    failsafe = stat.seen & stat.stale & sysArmed;
    armGate  = sensorCal & sysDisarmed & tiltOk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qualPrevQ  <= 1'b0;
      steerLoadQ <= 1'b0;
      armStartQ  <= 1'b0;
      cancelQ    <= 1'b0;
      disarmQ    <= 1'b0;
      aliveQ     <= 1'b0;
    end else begin
      qualPrevQ  <= qualNow;
      steerLoadQ <= chanValid;
      armStartQ  <= qualRise & armGate;
      cancelQ    <= qualFall | failsafe;
      disarmQ    <= (qualFall & sysArmed) | failsafe;
      aliveQ     <= stat.alive;
    end
  end

  always_comb begin
    strobe.capture   = chanValid;
    strobe.steerLoad = steerLoadQ;
    armStart         = armStartQ;
    cancelReq        = cancelQ;
    disarmReq        = disarmQ;
    linkAlive        = aliveQ;
  end
endmodule

// File: rtl/rc_arm_supervisor.sv
module rc_arm_supervisor
  import rc_sup_pkg::*;
#(
  parameter int CH_W       = 11,
  parameter int TIME_W     = 32,
  parameter int CMD_W      = 16,
  parameter int ARM_THRESH = 1750,
  parameter int TIMEOUT_MS = 300,
  parameter int RAW_MIN    = 172,
  parameter int RAW_MAX    = 1811,
  parameter int OUT_MAX    = 400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CH_W-1:0]         armChan,
  input  logic [CH_W-1:0]         steerChan,
  input  logic                    chanValid,
  input  logic [TIME_W-1:0]       nowMs,
  input  logic                    sensorCal,
  input  logic                    sysDisarmed,
  input  logic                    sysArmed,
  input  logic                    tiltOk,
  output logic                    armStart,
  output logic                    cancelReq,
  output logic                    disarmReq,
  output logic                    linkAlive,
  output logic signed [CMD_W-1:0] steerCmd
);
  ctrlStrobe_t strobe;
  linkStat_t   stat;

  rc_sup_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .chanValid  (chanValid),
    .stat       (stat),
    .sensorCal  (sensorCal),
    .sysDisarmed(sysDisarmed),
    .sysArmed   (sysArmed),
    .tiltOk     (tiltOk),
    .strobe     (strobe),
    .armStart   (armStart),
    .cancelReq  (cancelReq),
    .disarmReq  (disarmReq),
    .linkAlive  (linkAlive)
  );

  rc_sup_datapath #(
    .CH_W      (CH_W),
    .TIME_W    (TIME_W),
    .CMD_W     (CMD_W),
    .ARM_THRESH(ARM_THRESH),
    .TIMEOUT_MS(TIMEOUT_MS),
    .RAW_MIN   (RAW_MIN),
    .RAW_MAX   (RAW_MAX),
    .OUT_MAX   (OUT_MAX)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .armChan  (armChan),
    .steerChan(steerChan),
    .nowMs    (nowMs),
    .strobe   (strobe),
    .stat     (stat),
    .steerCmd (steerCmd)
  );
endmodule

// File: rtl/rc_arm_supervisor_chk.sv
module rc_arm_supervisor_chk #(
  parameter int CMD_W   = 16,
  parameter int OUT_MAX = 400
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    chanValid,
  input logic                    sensorCal,
  input logic                    sysDisarmed,
  input logic                    sysArmed,
  input logic                    tiltOk,
  input logic                    armStart,
  input logic                    cancelReq,
  input logic                    disarmReq,
  input logic                    linkAlive,
  input logic signed [CMD_W-1:0] steerCmd
);
  localparam logic signed [CMD_W-1:0] LIM = CMD_W'(OUT_MAX);

  // Independent record of whether any frame strobe has occurred.
  logic seenChk;
  always_ff @(posedge clk) begin
    if (!rst_n) seenChk <= 1'b0;
    else if (chanValid) seenChk <= 1'b1;
  end

  assert_arm_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armStart |-> $past(sensorCal && sysDisarmed && tiltOk));

  assert_arm_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armStart |=> !armStart);

  assert_arm_vs_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(armStart && cancelReq));

  assert_disarm_has_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disarmReq |-> cancelReq);

  assert_disarm_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disarmReq |-> $past(sysArmed));

  assert_no_failsafe_unseen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !seenChk |-> (!disarmReq && !cancelReq && !linkAlive));

  assert_steer_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (steerCmd <= LIM) && (steerCmd >= -LIM));
endmodule

bind rc_arm_supervisor rc_arm_supervisor_chk #(
  .CMD_W  (CMD_W),
  .OUT_MAX(OUT_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chanValid  (chanValid),
  .sensorCal  (sensorCal),
  .sysDisarmed(sysDisarmed),
  .sysArmed   (sysArmed),
  .tiltOk     (tiltOk),
  .armStart   (armStart),
  .cancelReq  (cancelReq),
  .disarmReq  (disarmReq),
  .linkAlive  (linkAlive),
  .steerCmd   (steerCmd)
);

// File: tb/rc_arm_supervisor_tb.sv
module rc_arm_supervisor_tb;
  logic               clk = 1'b0;
  logic               rst_n;
  logic [10:0]        armChan;
  logic [10:0]        steerChan;
  logic               chanValid;
  logic [31:0]        nowMs;
  logic               sensorCal;
  logic               sysDisarmed;
  logic               sysArmed;
  logic               tiltOk;
  logic               armStart;
  logic               cancelReq;
  logic               disarmReq;
  logic               linkAlive;
  logic signed [15:0] steerCmd;

  always #5 clk = ~clk;

  rc_arm_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .armChan(armChan), .steerChan(steerChan),
    .chanValid(chanValid), .nowMs(nowMs), .sensorCal(sensorCal),
    .sysDisarmed(sysDisarmed), .sysArmed(sysArmed), .tiltOk(tiltOk),
    .armStart(armStart), .cancelReq(cancelReq), .disarmReq(disarmReq),
    .linkAlive(linkAlive), .steerCmd(steerCmd)
  );

  typedef struct {
    int    due;
    bit    expArm;
    bit    expCancel;
    bit    expDisarm;
    bit    expAlive;
    int    expSteer;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int  cyc = 0;
  int  nCompared = 0;
  int  nMismatched = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations at the falling edge of their due cycle.
  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].due <= cyc) begin
      expItem_t it;
      it = scoreQ.pop_front();
      nCompared++;
      if (armStart !== it.expArm || cancelReq !== it.expCancel ||
          disarmReq !== it.expDisarm || linkAlive !== it.expAlive ||
          int'(steerCmd) != it.expSteer) begin
        nMismatched++;
        $display("FAIL %s: got arm=%0b cancel=%0b disarm=%0b alive=%0b steer=%0d, expected arm=%0b cancel=%0b disarm=%0b alive=%0b steer=%0d",
                 it.tag, armStart, cancelReq, disarmReq, linkAlive, int'(steerCmd),
                 it.expArm, it.expCancel, it.expDisarm, it.expAlive, it.expSteer);
      end
    end
  end

  task automatic expectIn(input int k, input bit a, input bit c, input bit d,
                          input bit al, input int st, input string tag);
    expItem_t it;
    it.due = cyc + k; it.expArm = a; it.expCancel = c; it.expDisarm = d;
    it.expAlive = al; it.expSteer = st; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive one frame strobe; returns at the falling edge after the capture edge.
  task automatic sendFrame(input int armRaw, input int steerRaw);
    armChan   = 11'(armRaw);
    steerChan = 11'(steerRaw);
    chanValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chanValid = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    armChan = 11'd992; steerChan = 11'd992; chanValid = 1'b0; nowMs = 32'd0;
    sensorCal = 1'b1; sysDisarmed = 1'b1; sysArmed = 1'b0; tiltOk = 1'b1;
    @(negedge clk);
    doReset();
    expectIn(1, 0, 0, 0, 0, 0, "R1 reset state"); idle(2);

    // R5: armed with no frame ever seen, lots of time passes
    sysArmed = 1'b1; sysDisarmed = 1'b0; nowMs = 32'd5000;
    expectIn(1, 0, 0, 0, 0, 0, "R5 no failsafe before first frame"); idle(4);
    expectIn(1, 0, 0, 0, 0, 0, "R5 still inhibited"); idle(2);
    sysArmed = 1'b0; sysDisarmed = 1'b1;

    nowMs = 32'd1000;
    sendFrame(1000, 992);
    expectIn(1, 0, 0, 0, 1, 0, "R3 alive after first frame, R8 midpoint"); idle(2);
    sendFrame(1750, 1500);
    expectIn(1, 0, 0, 0, 1, 248, "R2 value 1750 is off, R8 scaling"); idle(2);
    sendFrame(1751, 1811);
    expectIn(1, 1, 0, 0, 1, 400, "R2 R6 rising edge arms");
    expectIn(2, 0, 0, 0, 1, 400, "R6 arm pulse one cycle"); idle(3);
    sendFrame(1900, 172);
    expectIn(1, 0, 0, 0, 1, -400, "R6 level gives no repeat, R8 low end"); idle(2);
    sendFrame(1000, 500);
    expectIn(1, 0, 1, 0, 1, -240, "R7 falling edge cancel only when disarmed");
    expectIn(2, 0, 0, 0, 1, -240, "R7 cancel pulse one cycle"); idle(3);

    sysArmed = 1'b1; sysDisarmed = 1'b0;
    sendFrame(1800, 1000);
    expectIn(1, 0, 0, 0, 1, 4, "R6 no arm while not disarmed"); idle(2);
    sendFrame(1000, 100);
    expectIn(1, 0, 1, 1, 1, -400, "R7 falling edge disarms when armed, R8 clamp low"); idle(2);

    sysArmed = 1'b0; sysDisarmed = 1'b1; tiltOk = 1'b0;
    sendFrame(1800, 2000);
    expectIn(1, 0, 0, 0, 1, 400, "R6 tilt blocks arm, R8 clamp high"); idle(2);
    sendFrame(1000, 992);
    expectIn(1, 0, 1, 0, 1, 0, "R7 cancel after tilt-blocked edge"); idle(2);
    tiltOk = 1'b1; sensorCal = 1'b0;
    sendFrame(1800, 992);
    expectIn(1, 0, 0, 0, 1, 0, "R6 calibration blocks arm"); idle(2);
    sendFrame(1000, 992);
    expectIn(1, 0, 1, 0, 1, 0, "R7 cancel after cal-blocked edge"); idle(2);
    sensorCal = 1'b1;

    // R4 timeout with the switch off
    nowMs = 32'd2000;
    sendFrame(1000, 992);
    expectIn(1, 0, 0, 0, 1, 0, "R3 fresh frame"); idle(2);
    sysArmed = 1'b1; sysDisarmed = 1'b0; nowMs = 32'd2300;
    expectIn(1, 0, 0, 0, 1, 0, "R3 R4 exactly 300 ms still alive"); idle(2);
    nowMs = 32'd2301;
    expectIn(1, 0, 1, 1, 0, 0, "R4 failsafe at 301 ms");
    expectIn(2, 0, 1, 1, 0, 0, "R4 failsafe holds while armed"); idle(3);
    sysArmed = 1'b0; sysDisarmed = 1'b1;
    expectIn(1, 0, 0, 0, 0, 0, "R4 stale but not armed"); idle(2);

    // R7 link loss with the switch on
    nowMs = 32'd3000;
    sendFrame(1800, 992);
    expectIn(1, 1, 0, 0, 1, 0, "R6 arm after relink"); idle(2);
    nowMs = 32'd3301;
    expectIn(1, 0, 1, 0, 0, 0, "R7 link loss is a falling edge"); idle(2);

    // R10 wrap of the millisecond time
    nowMs = 32'hFFFF_FF00;
    sendFrame(1000, 992);
    expectIn(1, 0, 0, 0, 1, 0, "R10 frame near wrap"); idle(2);
    nowMs = 32'h0000_0020;
    expectIn(1, 0, 0, 0, 1, 0, "R10 288 ms across wrap alive"); idle(2);
    nowMs = 32'h0000_002D;
    expectIn(1, 0, 0, 0, 0, 0, "R10 301 ms across wrap stale"); idle(2);

    // R9 reset while switch on
    armChan = 11'd1800;
    doReset();
    expectIn(1, 0, 0, 0, 0, 0, "R1 second reset"); idle(2);
    sendFrame(1800, 992);
    expectIn(1, 1, 0, 0, 1, 0, "R9 first frame with switch on arms"); idle(3);

    if (scoreQ.size() != 0) begin
      nMismatched += scoreQ.size();
      $display("FAIL R1: %0d expectations never compared, expected 0", scoreQ.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nMismatched++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
      $finish;
    end
  end
endmodule